// File: doc/BRIEF.md
# Wave-Partitioned Vector Register File with Indirect Operand Addressing

This block holds the vector registers of one execution unit. The storage is split into fixed slices, one per hardware wave. Each wave always owns the same number of registers, and a wave that uses only a few of them leaves the rest idle. No other wave can use that spare space. Alongside the vector storage, every wave has a small bank of 16-bit address registers. An operand can name its vector register directly, or indirectly: a chosen address register plus a signed immediate offset gives the register index. Indirect naming is only allowed for operands of at most eight lanes.

There are two independent read ports, so an instruction can fetch two operands in one cycle. A read request carries the wave number, the addressing mode, a direct index or an address-register selector, the offset and the lane count. The result is registered and appears one cycle after the request. Lanes at or above the requested count read as zero. One vector register write port and one address register write port update the state.

Top module: `rfi_regfile`

## Requirements
- R1: Reset clears `rsp_vld`, `rsp_err` and `rsp_data` on both ports. It also clears every address register to 0, so an indirect read after reset uses the offset alone as the index.
- R2: A direct read (`rd_mode`=0) of wave w, index i returns the last value written to (w, i). The data appears with `rsp_vld`=1 in the cycle after the request.
- R3: Each wave owns 128 registers at physical location w*128+i. The same index in different waves names different storage.
- R4: An indirect read (`rd_mode`=1) uses the index (A + sign-extended `rd_off`) mod 128. A is the 16-bit address register `rd_asel` of the requesting wave.
- R5: An address register write (`aw_en`) is seen by indirect requests from the next cycle on. A request in the same cycle as the write uses the old value.
- R6: An indirect request with `rd_cnt` greater than 8 is rejected. The next cycle shows `rsp_err`=1, `rsp_vld`=0 and `rsp_data`=0, and no read happens. Direct requests with `rd_cnt` up to 16 are accepted.
- R7: Each register holds 16 lanes of 4 bits, with lane k in bits [4k+3:4k]. A response carries lanes below `rd_cnt` and zero in every lane at or above it. A count of 0 returns all-zero data with `rsp_vld`=1.
- R8: A read and a vector write to the same register in one cycle return the value held before the write. A later read returns the new value.
- R9: The two read ports serve unrelated requests in the same cycle, each with its own response.
- R10: The full 16-bit address register value takes part in the sum, and only the low 7 bits of the result select the register. For example, 0x0FFE plus offset 5 selects index 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_vld | input | 2 | Read request valid, one bit per port |
| rd_wave | input | 2x3 | Requesting wave per port |
| rd_mode | input | 2 | 0 direct, 1 indirect, per port |
| rd_idx | input | 2x7 | Direct register index per port |
| rd_asel | input | 2x3 | Address register selector per port |
| rd_off | input | 2x8 | Signed immediate offset per port |
| rd_cnt | input | 2x5 | Lane count per port |
| rsp_vld | output | 2 | Response data valid per port |
| rsp_err | output | 2 | Request rejected per port |
| rsp_data | output | 2x64 | Response data per port |
| vw_en | input | 1 | Vector register write enable |
| vw_wave | input | 3 | Wave of the vector write |
| vw_idx | input | 7 | Register index of the vector write |
| vw_data | input | 64 | Vector write data |
| aw_en | input | 1 | Address register write enable |
| aw_wave | input | 3 | Wave of the address register write |
| aw_sel | input | 3 | Address register number |
| aw_data | input | 16 | Address register write value |

## Verification
A wrong address register value or a broken index sum makes an indirect response return another register's pattern. This shows up one cycle after the request. The test patterns carry the wave and index in their upper bytes, so the mismatch names the register that was actually read. Partition faults look the same: a direct read returns a neighbouring wave's pattern. A fault in the count or mode decode shows up as a wrong `rsp_err`/`rsp_vld` pair, or as lanes left nonzero above the count, in that same response cycle. A read port that lets a same-cycle write through returns the new data one cycle early.

// File: rtl/rfi_pkg.sv
package rfi_pkg;

    localparam int NUM_WAVES     = 8;
    localparam int REGS_PER_WAVE = 128;
    localparam int LANES         = 16;
    localparam int LANE_W        = 4;
    localparam int AREGS         = 8;
    localparam int AREG_W        = 16;
    localparam int OFF_W         = 8;
    localparam int NRP           = 2;
    localparam int IND_MAX_LANES = 8;

    localparam int WAVE_W = $clog2(NUM_WAVES);
    localparam int IDX_W  = $clog2(REGS_PER_WAVE);
    localparam int ASEL_W = $clog2(AREGS);
    localparam int CNT_W  = $clog2(LANES) + 1;
    localparam int VREG_W = LANES * LANE_W;
    localparam int DEPTH  = NUM_WAVES * REGS_PER_WAVE;
    localparam int PHYS_W = $clog2(DEPTH);

    typedef enum logic {
        MODE_DIRECT   = 1'b0,
        MODE_INDIRECT = 1'b1
    } amode_e;

    typedef struct packed {
        logic              vld;
        logic [WAVE_W-1:0] wave;
        amode_e            mode;
        logic [IDX_W-1:0]  idx;
        logic [ASEL_W-1:0] asel;
        logic [OFF_W-1:0]  off;
        logic [CNT_W-1:0]  cnt;
    } rd_req_t;

    typedef struct packed {
        logic              fetch;
        logic              reject;
        logic [PHYS_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
    } rd_dec_t;

    typedef logic [NUM_WAVES-1:0][AREGS-1:0][AREG_W-1:0] areg_file_t;

    function automatic logic [VREG_W-1:0] lane_mask(input logic [CNT_W-1:0] cnt);
        logic [VREG_W-1:0] m;
        m = '0;
        for (int l = 0; l < LANES; l++) begin
            if (l < int'(cnt)) begin
                m[l*LANE_W +: LANE_W] = {LANE_W{1'b1}};
            end
        end
        return m;
    endfunction

    function automatic logic [IDX_W-1:0] eff_index(input logic [AREG_W-1:0] base,
                                                    input logic [OFF_W-1:0]  off);
        logic [AREG_W-1:0] sum;
        sum = base + AREG_W'($signed(off));
        return sum[IDX_W-1:0];
    endfunction

    function automatic logic [PHYS_W-1:0] phys_addr(input logic [WAVE_W-1:0] wave,
                                                     input logic [IDX_W-1:0]  idx);
        return PHYS_W'(wave) * PHYS_W'(REGS_PER_WAVE) + PHYS_W'(idx);
    endfunction

endpackage

// File: rtl/rfi_areg_bank.sv
module rfi_areg_bank
    import rfi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WAVE_W-1:0] wr_wave,
    input  logic [ASEL_W-1:0] wr_sel,
    input  logic [AREG_W-1:0] wr_data,
    output areg_file_t        regs
);

    for (genvar w = 0; w < NUM_WAVES; w++) begin : g_wave
        for (genvar a = 0; a < AREGS; a++) begin : g_areg
            logic hit;
            assign hit = wr_en && (wr_wave == WAVE_W'(w)) && (wr_sel == ASEL_W'(a));
            always_ff @(posedge clk) begin
                if (rst) begin
                    regs[w][a] <= '0;
                end else if (hit) begin
                    regs[w][a] <= wr_data;
                end
            end
        end
    end

endmodule

// File: rtl/rfi_addr_gen.sv
module rfi_addr_gen
    import rfi_pkg::*;
(
    input  rd_req_t    req,
    input  areg_file_t regs,
    output rd_dec_t    dec
);

    logic [AREG_W-1:0] base;
    logic [IDX_W-1:0]  idx_eff;
    logic              too_wide;

    always_comb begin
        base     = regs[req.wave][req.asel];
        too_wide = (req.cnt > CNT_W'(IND_MAX_LANES));
        if (req.mode == MODE_INDIRECT) begin
            idx_eff = eff_index(base, req.off);
        end else begin
            idx_eff = req.idx;
        end
        dec.reject = req.vld && (req.mode == MODE_INDIRECT) && too_wide;
        dec.fetch  = req.vld && !dec.reject;
        dec.addr   = phys_addr(req.wave, idx_eff);
        dec.cnt    = req.cnt;
    end

endmodule

// File: rtl/rfi_vec_store.sv
module rfi_vec_store
    import rfi_pkg::*;
(
    input  logic                        clk,
    input  logic                        wr_en,
    input  logic [PHYS_W-1:0]           wr_addr,
    input  logic [VREG_W-1:0]           wr_data,
    input  logic [NRP-1:0]              rd_en,
    input  logic [NRP-1:0][PHYS_W-1:0]  rd_addr,
    output logic [NRP-1:0][VREG_W-1:0]  rd_data
);

    logic [VREG_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    for (genvar p = 0; p < NRP; p++) begin : g_rport
        always_ff @(posedge clk) begin
            if (rd_en[p]) begin
                rd_data[p] <= mem[rd_addr[p]];
            end
        end
    end

endmodule

// File: rtl/rfi_regfile.sv
module rfi_regfile
    import rfi_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NRP-1:0]              rd_vld,
    input  logic [NRP-1:0][WAVE_W-1:0]  rd_wave,
    input  logic [NRP-1:0]              rd_mode,
    input  logic [NRP-1:0][IDX_W-1:0]   rd_idx,
    input  logic [NRP-1:0][ASEL_W-1:0]  rd_asel,
    input  logic [NRP-1:0][OFF_W-1:0]   rd_off,
    input  logic [NRP-1:0][CNT_W-1:0]   rd_cnt,
    output logic [NRP-1:0]              rsp_vld,
    output logic [NRP-1:0]              rsp_err,
    output logic [NRP-1:0][VREG_W-1:0]  rsp_data,
    input  logic                        vw_en,
    input  logic [WAVE_W-1:0]           vw_wave,
    input  logic [IDX_W-1:0]            vw_idx,
    input  logic [VREG_W-1:0]           vw_data,
    input  logic                        aw_en,
    input  logic [WAVE_W-1:0]           aw_wave,
    input  logic [ASEL_W-1:0]           aw_sel,
    input  logic [AREG_W-1:0]           aw_data
);

    areg_file_t                  aregs;
    rd_dec_t [NRP-1:0]           dec;
    logic [NRP-1:0]              fetch;
    logic [NRP-1:0][PHYS_W-1:0]  fetch_addr;
    logic [NRP-1:0][VREG_W-1:0]  raw_data;
    logic [NRP-1:0][CNT_W-1:0]   cnt_q;

    rfi_areg_bank u_areg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (aw_en),
        .wr_wave (aw_wave),
        .wr_sel  (aw_sel),
        .wr_data (aw_data),
        .regs    (aregs)
    );

    for (genvar p = 0; p < NRP; p++) begin : g_port
        rd_req_t req;

        always_comb begin
            req.vld  = rd_vld[p];
            req.wave = rd_wave[p];
            req.mode = amode_e'(rd_mode[p]);
            req.idx  = rd_idx[p];
            req.asel = rd_asel[p];
            req.off  = rd_off[p];
            req.cnt  = rd_cnt[p];
        end

        rfi_addr_gen u_agen (
            .req  (req),
            .regs (aregs),
            .dec  (dec[p])
        );

        assign fetch[p]      = dec[p].fetch;
        assign fetch_addr[p] = dec[p].addr;

        always_ff @(posedge clk) begin
            if (rst) begin
                rsp_vld[p] <= 1'b0;
                rsp_err[p] <= 1'b0;
                cnt_q[p]   <= '0;
            end else begin
                rsp_vld[p] <= dec[p].fetch;
                rsp_err[p] <= dec[p].reject;
                cnt_q[p]   <= dec[p].cnt;
            end
        end

        assign rsp_data[p] = rsp_vld[p] ? (raw_data[p] & lane_mask(cnt_q[p])) : '0;
    end

    rfi_vec_store u_store (
        .clk     (clk),
        .wr_en   (vw_en),
        .wr_addr (phys_addr(vw_wave, vw_idx)),
        .wr_data (vw_data),
        .rd_en   (fetch),
        .rd_addr (fetch_addr),
        .rd_data (raw_data)
    );

endmodule

// File: rtl/rfi_regfile_chk.sv
module rfi_regfile_chk
    import rfi_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NRP-1:0]              rd_vld,
    input  logic [NRP-1:0]              rd_mode,
    input  logic [NRP-1:0][CNT_W-1:0]   rd_cnt,
    input  logic [NRP-1:0]              rsp_vld,
    input  logic [NRP-1:0]              rsp_err,
    input  logic [NRP-1:0][VREG_W-1:0]  rsp_data
);

    for (genvar p = 0; p < NRP; p++) begin : g_chk
        AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
            rsp_vld[p] == ($past(rd_vld[p]) && !$past(rst) &&
                           !($past(rd_mode[p]) && $past(rd_cnt[p]) > CNT_W'(IND_MAX_LANES)))); // R2
        AST_ERR_ONLY_WIDE_IND: assert property (@(posedge clk) disable iff (rst)
            rsp_err[p] |-> ($past(rd_vld[p]) && $past(rd_mode[p]) &&
                            $past(rd_cnt[p]) > CNT_W'(IND_MAX_LANES))); // R6
        AST_ERR_NOT_VALID: assert property (@(posedge clk) disable iff (rst)
            !(rsp_err[p] && rsp_vld[p])); // R6
        AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
            !rsp_vld[p] |-> (rsp_data[p] == '0)); // R6
        AST_LANES_ABOVE_CNT: assert property (@(posedge clk) disable iff (rst)
            rsp_vld[p] |-> ((rsp_data[p] & ~lane_mask($past(rd_cnt[p]))) == '0)); // R7
    end

endmodule

bind rfi_regfile rfi_regfile_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_vld   (rd_vld),
    .rd_mode  (rd_mode),
    .rd_cnt   (rd_cnt),
    .rsp_vld  (rsp_vld),
    .rsp_err  (rsp_err),
    .rsp_data (rsp_data)
);

// File: tb/sim_rfi_regfile.sv
`timescale 1ns/100ps
module sim_rfi_regfile;
    import rfi_pkg::*;

    logic                        clk = 1'b0;
    logic                        rst = 1'b1;
    logic [NRP-1:0]              rd_vld = '0;
    logic [NRP-1:0][WAVE_W-1:0]  rd_wave = '0;
    logic [NRP-1:0]              rd_mode = '0;
    logic [NRP-1:0][IDX_W-1:0]   rd_idx = '0;
    logic [NRP-1:0][ASEL_W-1:0]  rd_asel = '0;
    logic [NRP-1:0][OFF_W-1:0]   rd_off = '0;
    logic [NRP-1:0][CNT_W-1:0]   rd_cnt = '0;
    logic [NRP-1:0]              rsp_vld;
    logic [NRP-1:0]              rsp_err;
    logic [NRP-1:0][VREG_W-1:0]  rsp_data;
    logic                        vw_en = 1'b0;
    logic [WAVE_W-1:0]           vw_wave = '0;
    logic [IDX_W-1:0]            vw_idx = '0;
    logic [VREG_W-1:0]           vw_data = '0;
    logic                        aw_en = 1'b0;
    logic [WAVE_W-1:0]           aw_wave = '0;
    logic [ASEL_W-1:0]           aw_sel = '0;
    logic [AREG_W-1:0]           aw_data = '0;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    rfi_regfile u0 (.*);

    localparam int NV = 12;
    localparam int TW [NV] = '{0, 1, 7, 2, 1, 1, 1, 1, 3, 3, 5, 0};
    localparam int TI [NV] = '{0, 0, 127, 3, 7, 10, 20, 3, 50, 51, 64, 1};

    function automatic logic [63:0] pat(input int w, input int i);
        return {8'(w), 8'(i), ~8'(w), ~8'(i), 32'h1357_9BDF};
    endfunction

    function automatic logic [63:0] tb_mask(input int cnt);
        logic [63:0] m = '0;
        for (int k = 0; k < 16; k++) if (k < cnt) m[k*4 +: 4] = 4'hF;
        return m;
    endfunction

    task automatic step();
        @(negedge clk);
        rd_vld = '0;
        vw_en  = 1'b0;
        aw_en  = 1'b0;
    endtask

    task automatic set_rd(input int p, input int w, input bit ind, input int idx,
                          input int asel, input int off, input int cnt);
        rd_vld[p]  = 1'b1;
        rd_wave[p] = WAVE_W'(w);
        rd_mode[p] = ind;
        rd_idx[p]  = IDX_W'(idx);
        rd_asel[p] = ASEL_W'(asel);
        rd_off[p]  = OFF_W'(off);
        rd_cnt[p]  = CNT_W'(cnt);
    endtask

    task automatic set_vw(input int w, input int i, input logic [63:0] d);
        vw_en = 1'b1; vw_wave = WAVE_W'(w); vw_idx = IDX_W'(i); vw_data = d;
    endtask

    task automatic set_aw(input int w, input int s, input logic [15:0] d);
        aw_en = 1'b1; aw_wave = WAVE_W'(w); aw_sel = ASEL_W'(s); aw_data = d;
    endtask

    task automatic chk(input int p, input bit ev, input bit ee, input logic [63:0] ed,
                       input string req);
        checks++;
        if (rsp_vld[p] !== ev || rsp_err[p] !== ee || rsp_data[p] !== ed) begin
            fails++;
            $display("FAIL %s port%0d: actual vld=%0b err=%0b data=%h expected vld=%0b err=%0b data=%h",
                     req, p, rsp_vld[p], rsp_err[p], rsp_data[p], ev, ee, ed);
        end
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(0, 0, 0, '0, "R1 reset");
        chk(1, 0, 0, '0, "R1 reset");
        rst = 1'b0;

        // Table walk: fill, then read back over alternating ports (R2, R3)
        for (int n = 0; n < NV; n++) begin
            set_vw(TW[n], TI[n], pat(TW[n], TI[n]));
            step();
        end
        for (int n = 0; n < NV; n++) begin
            set_rd(n % 2, TW[n], 1'b0, TI[n], 0, 0, 16);
            step();
            chk(n % 2, 1, 0, pat(TW[n], TI[n]), "R2 R3 table");
        end

        // R1: address registers are zero after reset
        set_rd(0, 2, 1'b1, 0, 5, 3, 8);
        step();
        chk(0, 1, 0, pat(2, 3) & tb_mask(8), "R1 areg zero");

        // R4: base plus negative offset
        set_aw(1, 2, 16'd10);
        step();
        set_rd(1, 1, 1'b1, 0, 2, -3, 8);
        step();
        chk(1, 1, 0, pat(1, 7) & tb_mask(8), "R4 indirect");

        // R4: negative wrap inside the partition, 0 - 78 -> 50
        set_rd(0, 3, 1'b1, 0, 0, -78, 8);
        step();
        chk(0, 1, 0, pat(3, 50) & tb_mask(8), "R4 wrap");

        // R5: same-cycle address write not yet visible
        set_aw(1, 2, 16'd20);
        set_rd(0, 1, 1'b1, 0, 2, 0, 8);
        step();
        chk(0, 1, 0, pat(1, 10) & tb_mask(8), "R5 old areg");
        set_rd(0, 1, 1'b1, 0, 2, 0, 8);
        step();
        chk(0, 1, 0, pat(1, 20) & tb_mask(8), "R5 new areg");

        // R10: 16-bit sum truncated to 7 bits
        set_aw(1, 3, 16'h0FFE);
        step();
        set_rd(1, 1, 1'b1, 0, 3, 5, 8);
        step();
        chk(1, 1, 0, pat(1, 3) & tb_mask(8), "R10 truncation");

        // R6: wide indirect rejected, direct wide accepted
        set_rd(1, 1, 1'b1, 0, 2, 0, 16);
        set_rd(0, 1, 1'b1, 0, 2, 0, 9);
        step();
        chk(1, 0, 1, '0, "R6 reject cnt16");
        chk(0, 0, 1, '0, "R6 reject cnt9");
        step();
        chk(0, 0, 0, '0, "R6 err one cycle");
        set_rd(0, 0, 1'b0, 0, 0, 0, 16);
        step();
        chk(0, 1, 0, pat(0, 0), "R6 direct cnt16");

        // R7: lane masking
        set_rd(1, 5, 1'b0, 64, 0, 0, 3);
        step();
        chk(1, 1, 0, pat(5, 64) & tb_mask(3), "R7 cnt3");
        set_rd(1, 5, 1'b0, 64, 0, 0, 0);
        step();
        chk(1, 1, 0, '0, "R7 cnt0");

        // R8: read during write returns old value
        set_vw(3, 51, 64'hDEAD_BEEF_0BAD_F00D);
        set_rd(0, 3, 1'b0, 51, 0, 0, 16);
        step();
        chk(0, 1, 0, pat(3, 51), "R8 old data");
        set_rd(0, 3, 1'b0, 51, 0, 0, 16);
        step();
        chk(0, 1, 0, 64'hDEAD_BEEF_0BAD_F00D, "R8 new data");

        // R9: both ports in one cycle
        set_rd(0, 7, 1'b0, 127, 0, 0, 16);
        set_rd(1, 0, 1'b0, 1, 0, 0, 16);
        step();
        chk(0, 1, 0, pat(7, 127), "R9 port0");
        chk(1, 1, 0, pat(0, 1), "R9 port1");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule